// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to the device-to-host direction of a PS/2 keyboard port. Both open-collector lines are brought into the system clock domain through a synchroniser. The clock line then passes through a run-length glitch filter, and the filtered clock is watched for falling edges. On each falling edge the block samples the data line and collects an 11-bit word. When the word is complete it checks the start bit, the odd parity and the stop bit, and reports a framing or parity error if any of them is wrong.

Good bytes go to a prefix tracker. The tracker folds the release prefix (F0), the extended prefix (E0) and the combined extended-release sequence (E0 F0) into a single key event. Each event carries an 8-bit scan code, an extended flag and a release flag.

Events leave the block on a valid/ready stream. An event stays on the outputs, unchanged, until the consumer accepts it. If another event completes while an unaccepted one is held, the new event is lost and the held one is kept. If the consumer accepts in the same cycle that a new event completes, the new event is loaded and nothing is lost. The two error outputs are plain single-cycle pulses and are not subject to back-pressure.

Top module: `ps2_key_rx`

## Requirements
- R1: While reset is asserted, and after it is released with idle lines, `evt_valid`, `frame_err` and `parity_err` are all 0.
- R2: A good word carrying a byte other than E0 or F0, with no pending prefix, yields one event with that code, `evt_ext`=0 and `evt_rel`=0. A good word has bit 0 (start) = 0, bits 1..8 = data with the LSB first, bit 9 = parity making the nine bits odd, and bit 10 (stop) = 1.
- R3: The byte F0 followed by a code yields one event with `evt_rel`=1 and `evt_ext`=0. The prefix byte itself produces no event.
- R4: E0 followed by a code yields `evt_ext`=1 and `evt_rel`=0. E0 F0 followed by a code yields `evt_ext`=1 and `evt_rel`=1. Neither prefix byte produces an event.
- R5: The same code received several times in a row yields one make event each time.
- R6: A word with a correct start bit and stop bit but even parity raises `parity_err` for one cycle, produces no event, and clears any pending prefix.
- R7: A word whose start bit is 1 or whose stop bit is 0 raises `frame_err` for one cycle, produces no event, and clears any pending prefix. When framing and parity are both bad, only `frame_err` is raised.
- R8: If a word stops partway and no falling edge arrives for TIMEOUT_CYC system cycles, the partial word is dropped without an error. The next complete word is then decoded normally.
- R9: A low pulse on the device clock lasting fewer than FILT_LEN system cycles is ignored, whether it occurs while the bus is idle or in the middle of a word.
- R10: While `evt_valid`=1 and `evt_ready`=0, the event outputs hold their values. An event that completes during this time is discarded, and its prefixes are still consumed.
- R11: An event becomes valid FILT_LEN+4 system cycles after the device clock falls for the stop bit. A handshake in that same cycle does not lose the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Device clock line (idle high) |
| ps2_dat_i | input | 1 | Device data line (idle high) |
| evt_valid | output | 1 | Key event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_code | output | 8 | Scan code of the event |
| evt_ext | output | 1 | Event came from an extended key |
| evt_rel | output | 1 | Event is a key release |
| frame_err | output | 1 | One-cycle pulse: start or stop bit wrong |
| parity_err | output | 1 | One-cycle pulse: parity not odd |

## Verification
Two things can happen in the same cycle at the output stage: a new event is loaded, and the held event is handed off. To provoke this, the bench holds one event with ready low and then sends a second word. It stops the device clock low right at the stop-bit edge and raises ready for a single cycle, sweeping that cycle from one to twelve cycles after the edge. The expected number of delivered events is computed from the stated latency: both events are delivered when ready comes no later than the load cycle, and only the held one when ready comes after it.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam logic [7:0] PFX_EXTENDED = 8'hE0;
  localparam logic [7:0] PFX_RELEASE  = 8'hF0;
  localparam int         WORD_BITS    = 11;

  typedef struct packed {
    logic       ext;
    logic       rel;
    logic [7:0] code;
  } key_evt_t;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_raw,
  input  logic dat_raw,
  output logic dat_s,
  output logic fall
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

  logic [1:0]             raw_w;
  logic [SYNC_STAGES-1:0] chain [2];
  logic                   clk_s;
  logic                   filt, filt_d;
  logic [CW-1:0]          run_cnt;

  assign raw_w = {dat_raw, clk_raw};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '1;
      else        chain[g] <= {chain[g][SYNC_STAGES-2:0], raw_w[g]};
    end
  end

  assign clk_s = chain[0][SYNC_STAGES-1];
  assign dat_s = chain[1][SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt    <= 1'b1;
      filt_d  <= 1'b1;
      run_cnt <= '0;
    end else begin
      filt_d <= filt;
      if (clk_s != filt) begin
        if (run_cnt == CW'(FILT_LEN - 1)) begin
          filt    <= clk_s;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end

  assign fall = filt_d & ~filt;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall); // R9
  AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n) $fell(filt) |-> (!$past(clk_s, 1) && !$past(clk_s, 2))); // R9
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall,
  input  logic       dat_s,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       frame_err,
  output logic       parity_err
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int BW = $clog2(WORD_BITS + 1);

  logic [BW-1:0]          bit_cnt;
  logic [WORD_BITS-2:0]   shreg;
  logic [TW-1:0]          idle_cnt;
  logic [WORD_BITS-1:0]   word;

  assign word = {dat_s, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      idle_cnt   <= '0;
      byte_vld   <= 1'b0;
      byte_q     <= '0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      byte_vld   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      if (fall) begin
        idle_cnt <= '0;
        if (bit_cnt == BW'(WORD_BITS - 1)) begin
          bit_cnt <= '0;
          if (word[0] || !word[WORD_BITS-1]) frame_err <= 1'b1;
          else if (!(^word[9:1]))            parity_err <= 1'b1;
          else begin
            byte_vld <= 1'b1;
            byte_q   <= word[8:1];
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {dat_s, shreg[WORD_BITS-2:1]};
        end
      end else if (bit_cnt != '0) begin
        if (idle_cnt >= TW'(TIMEOUT_CYC - 1)) begin
          bit_cnt  <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt <= BW'(WORD_BITS - 1)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({byte_vld, frame_err, parity_err})); // R6
  AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!fall && bit_cnt != '0 && idle_cnt == TW'(TIMEOUT_CYC - 1)) |=> bit_cnt == '0); // R8
endmodule

// File: rtl/ps2_key_decode.sv
module ps2_key_decode
  import ps2_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     byte_vld,
  input  logic [7:0] byte_q,
  input  logic     word_err,
  output key_evt_t evt,
  output logic     evt_valid,
  input  logic     evt_ready
);
  logic ext_p, rel_p;
  logic is_pfx, take;

  assign is_pfx = (byte_q == PFX_EXTENDED) || (byte_q == PFX_RELEASE);
  assign take   = byte_vld && !is_pfx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_p <= 1'b0;
      rel_p <= 1'b0;
    end else if (word_err) begin
      ext_p <= 1'b0;
      rel_p <= 1'b0;
    end else if (byte_vld) begin
      if (byte_q == PFX_EXTENDED)     ext_p <= 1'b1;
      else if (byte_q == PFX_RELEASE) rel_p <= 1'b1;
      else begin
        ext_p <= 1'b0;
        rel_p <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt       <= '0;
      evt_valid <= 1'b0;
    end else begin
      if (evt_valid && evt_ready) evt_valid <= 1'b0;
      if (take && (!evt_valid || evt_ready)) begin
        evt       <= '{ext: ext_p, rel: rel_p, code: byte_q};
        evt_valid <= 1'b1;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt))); // R10
  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (byte_vld && is_pfx && !evt_valid) |=> !evt_valid); // R4
  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (evt_valid && evt_ready && take) |=> evt_valid); // R11
endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx
  import ps2_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       evt_valid,
  input  logic       evt_ready,
  output logic [7:0] evt_code,
  output logic       evt_ext,
  output logic       evt_rel,
  output logic       frame_err,
  output logic       parity_err
);
  logic       dat_s, fall;
  logic       byte_vld;
  logic [7:0] byte_q;
  key_evt_t   evt;

  ps2_line_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) sync_i (
    .clk(clk), .rst_n(rst_n), .clk_raw(ps2_clk_i), .dat_raw(ps2_dat_i),
    .dat_s(dat_s), .fall(fall)
  );

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) frame_i (
    .clk(clk), .rst_n(rst_n), .fall(fall), .dat_s(dat_s),
    .byte_vld(byte_vld), .byte_q(byte_q),
    .frame_err(frame_err), .parity_err(parity_err)
  );

  ps2_key_decode dec_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_q(byte_q),
    .word_err(frame_err | parity_err),
    .evt(evt), .evt_valid(evt_valid), .evt_ready(evt_ready)
  );

  assign evt_code = evt.code;
  assign evt_ext  = evt.ext;
  assign evt_rel  = evt.rel;

  AST_ERR_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n) (frame_err && !evt_valid) |=> !evt_valid); // R7
endmodule

// File: tb/ps2_key_rx_tb_top.sv
module ps2_key_rx_tb_top;
  localparam int FILT = 4;
  localparam int TO   = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps2_clk = 1'b1, ps2_dat = 1'b1, evt_ready = 1'b1;
  logic evt_valid, evt_ext, evt_rel, frame_err, parity_err;
  logic [7:0] evt_code;

  int n_chk = 0, n_err = 0;
  int n_ev = 0, n_ferr = 0, n_perr = 0;
  logic [7:0] last_code = '0;
  logic last_ext = 1'b0, last_rel = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ps2_key_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
    .evt_ext(evt_ext), .evt_rel(evt_rel),
    .frame_err(frame_err), .parity_err(parity_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid && evt_ready) begin
        n_ev++;
        last_code = evt_code;
        last_ext  = evt_ext;
        last_rel  = evt_rel;
      end
      if (frame_err)  n_ferr++;
      if (parity_err) n_perr++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [10:0] mkword(input logic [7:0] b, input bit bad_par,
                                         input bit bad_start, input bit bad_stop);
    logic p;
    p = (~^b) ^ bad_par;
    return {~bad_stop, p, b, bad_start};
  endfunction

  task automatic send_bits(input logic [10:0] w, input int nb, input bit leave_low);
    for (int i = 0; i < nb; i++) begin
      ps2_dat = w[i];
      wcyc(10);
      ps2_clk = 1'b0;
      if (leave_low && i == nb - 1) return;
      wcyc(20);
      ps2_clk = 1'b1;
      wcyc(10);
    end
    ps2_dat = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(mkword(b, 1'b0, 1'b0, 1'b0), 11, 1'b0);
    wcyc(60);
  endtask

  task automatic expect_evt(input string req, input int base, input logic [7:0] c,
                            input bit e, input bit r);
    chk(n_ev == base + 1, req, n_ev - base, 1);
    chk({last_ext, last_rel, last_code} == {e, r, c}, req,
        {last_ext, last_rel, last_code}, {e, r, c});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base, bf;
    int mode;
    logic [7:0] c;
    wcyc(5);
    chk(!evt_valid && !frame_err && !parity_err, "R1 in reset",
        {evt_valid, frame_err, parity_err}, 0);
    rst_n = 1'b1;
    wcyc(20);
    chk(!evt_valid && !frame_err && !parity_err, "R1 after reset",
        {evt_valid, frame_err, parity_err}, 0);

    // R2 R3 R4 sweep over codes and all four prefix modes
    for (int i = 1; i < 256; i += 5) begin
      c = 8'(i);
      if (c == 8'hE0 || c == 8'hF0) continue;
      mode = (i / 5) % 4;
      base = n_ev;
      if (mode >= 2) send_byte(8'hE0);
      if (mode == 1 || mode == 3) send_byte(8'hF0);
      chk(n_ev == base, "R4 prefix silent", n_ev - base, 0);
      send_byte(c);
      expect_evt(mode == 0 ? "R2 make" : (mode == 1 ? "R3 release" : "R4 extended"),
                 base, c, mode >= 2, mode == 1 || mode == 3);
    end

    // R5 repeated make events
    for (int k = 0; k < 3; k++) begin
      base = n_ev;
      send_byte(8'h1C);
      expect_evt("R5 repeat", base, 8'h1C, 1'b0, 1'b0);
    end

    // R6 parity error clears pending release prefix
    send_byte(8'hF0);
    base = n_ev; bf = n_perr;
    send_bits(mkword(8'h15, 1'b1, 1'b0, 1'b0), 11, 1'b0);
    wcyc(60);
    chk(n_perr == bf + 1, "R6 parity pulse", n_perr - bf, 1);
    chk(n_ev == base, "R6 no event", n_ev - base, 0);
    send_byte(8'h15);
    expect_evt("R6 prefix cleared", base, 8'h15, 1'b0, 1'b0);

    // R7 bad start, bad stop, both bad with bad parity
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hE0);
      base = n_ev; bf = n_ferr;
      c = n_perr[7:0];
      send_bits(mkword(8'h16, k == 2, k != 1, k != 0), 11, 1'b0);
      wcyc(60);
      chk(n_ferr == bf + 1, "R7 frame pulse", n_ferr - bf, 1);
      chk(n_perr[7:0] == c, "R7 no parity pulse", n_perr[7:0], c);
      send_byte(8'h16);
      expect_evt("R7 prefix cleared", base, 8'h16, 1'b0, 1'b0);
    end

    // R8 partial word then gap beyond timeout
    base = n_ev; bf = n_ferr + n_perr;
    send_bits(mkword(8'h77, 1'b0, 1'b0, 1'b0), 4, 1'b0);
    ps2_dat = 1'b1;
    wcyc(TO + 100);
    send_byte(8'h2A);
    expect_evt("R8 after timeout", base, 8'h2A, 1'b0, 1'b0);
    chk(n_ferr + n_perr == bf, "R8 no error", n_ferr + n_perr - bf, 0);

    // R9 short glitch while idle
    base = n_ev; bf = n_ferr + n_perr;
    ps2_clk = 1'b0; wcyc(FILT - 1); ps2_clk = 1'b1; wcyc(30);
    send_byte(8'h3B);
    expect_evt("R9 idle glitch", base, 8'h3B, 1'b0, 1'b0);
    // R9 glitch in middle of word (clock-high phase of bit 5)
    base = n_ev;
    send_bits(mkword(8'h4C, 1'b0, 1'b0, 1'b0), 5, 1'b0);
    ps2_clk = 1'b0; wcyc(FILT - 1); ps2_clk = 1'b1; wcyc(10);
    send_bits(mkword(8'h4C, 1'b0, 1'b0, 1'b0) >> 5, 6, 1'b0);
    wcyc(60);
    expect_evt("R9 mid-word glitch", base, 8'h4C, 1'b0, 1'b0);
    chk(n_ferr + n_perr == bf, "R9 no error", n_ferr + n_perr - bf, 0);

    // R10 hold under back-pressure, second event dropped
    evt_ready = 1'b0;
    base = n_ev;
    send_byte(8'h33);
    chk(evt_valid && evt_code == 8'h33, "R10 held", evt_code, 8'h33);
    send_byte(8'hF0);
    send_byte(8'h34);
    chk(evt_valid && evt_code == 8'h33 && !evt_rel, "R10 stable", evt_code, 8'h33);
    evt_ready = 1'b1;
    wcyc(3);
    chk(n_ev == base + 1 && last_code == 8'h33, "R10 single delivery", n_ev - base, 1);
    chk(!evt_valid, "R10 drained", evt_valid, 0);
    base = n_ev;
    send_byte(8'h35);
    expect_evt("R10 release prefix consumed", base, 8'h35, 1'b0, 1'b0);

    // R11 sweep of a one-cycle ready pulse around the load cycle
    for (int d = 1; d <= 12; d++) begin
      evt_ready = 1'b0;
      base = n_ev;
      send_byte(8'h21);
      send_bits(mkword(8'h22, 1'b0, 1'b0, 1'b0), 11, 1'b1);
      wcyc(d);
      evt_ready = 1'b1;
      wcyc(1);
      evt_ready = 1'b0;
      wcyc(20 - (d + 1));
      ps2_clk = 1'b1;
      ps2_dat = 1'b1;
      wcyc(30);
      evt_ready = 1'b1;
      wcyc(5);
      chk(n_ev - base == ((d <= FILT + 3) ? 2 : 1), "R11 deliveries", n_ev - base,
          (d <= FILT + 3) ? 2 : 1);
      chk(last_code == ((d <= FILT + 3) ? 8'h22 : 8'h21), "R11 last code", last_code,
          (d <= FILT + 3) ? 8'h22 : 8'h21);
    end

    finish_run();
  end
endmodule